// File: doc/BRIEF.md
# IF Counter Station-Stop Detector

This block decides whether a receiver tuned during a search has landed on a station whose intermediate frequency is centred. It counts rising edges of a squared-up IF pulse input during a gate whose length comes from the reference oscillator clock. It compares that count with the count a correctly centred IF would give, using a programmable tolerance. The per-gate verdicts are smoothed by a 5-bit up/down filter counter, and the filter drives a search-stop flag with hysteresis.

Each gate gives one verdict, presented as a one-cycle `meas_strobe` with `meas_pass` beside it. The filter starts at its midpoint, 16, whenever the enable rises. The search-stop flag drops once enough consecutive good gates pull the filter a programmed step below the midpoint. It returns high when failures push the filter the same step above the midpoint. The IF input is treated as a digital signal; analog limiting happens elsewhere. The block has no data stream, so all of its pins are plain control and status signals with no handshake.

Top module: `ifc_station_stop`

## Requirements
- R1: `if_mode` 2'b01 selects FM, with a base count of 1697. 2'b10 selects AM, with a base count of 44. Codes 2'b00 and 2'b11 are unused: while either is applied, no measurement completes, no `meas_strobe` appears, and `search_stop` keeps its value.
- R2: A gate lasts (`ref_div`+1)·(`gate_mult`+1) clock cycles. Gates run back to back. The first gate starts in the cycle after the enable rise is seen, so the first `meas_strobe` comes G+1 cycles after `ifena` is raised, where G is the gate length.
- R3: The expected count is N = `center_trim` + base count. The main down-counter is loaded with N−1 at the start of each gate and loses one per synchronized rising edge of `if_in`. Exactly N edges leave it at all ones, having wrapped through zero.
- R4: With E edges counted in a gate, `meas_pass` is 1 exactly when |E−N| < 2^`win_sel`.
- R5: `meas_pass` is high only in a cycle where `meas_strobe` is high. `meas_strobe` lasts one cycle per completed gate.
- R6: A rising edge of `ifena` presets the filter to 16 and sets `search_stop` to 1. While `ifena` is low, `search_stop` is 1 and no new gate completes.
- R7: Each failing verdict raises the filter by one, saturating at 31. Each passing verdict lowers it by one, saturating at 0.
- R8: `search_stop` falls when the filter reaches 16−`stop_step`. It rises when the filter reaches 16+`stop_step`. With `stop_step` = 0 the rise condition wins, so the flag stays 1.
- R9: During reset, `search_stop` is 1 and `meas_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | Squared IF pulse input (asynchronous) |
| ifena | input | 1 | Measurement enable; its rising edge restarts everything |
| if_mode | input | 2 | Mode code: 01 FM, 10 AM, others unused |
| win_sel | input | 3 | Tolerance exponent; window half-width is 2^win_sel edges |
| center_trim | input | 5 | Centre-frequency trim added to the base count |
| gate_mult | input | 3 | Number of timer periods per gate, minus one |
| ref_div | input | 14 | Sample timer period in clock cycles, minus one |
| stop_step | input | 4 | Hysteresis step of the filter around 16 |
| meas_strobe | output | 1 | One-cycle pulse when a gate's verdict is ready |
| meas_pass | output | 1 | Verdict of the gate; valid with meas_strobe |
| search_stop | output | 1 | Search-stop flag; 0 means a station is held |

## Verification
On every cycle, the assertions check the following: strobes only ever follow a valid mode; a low enable forces the flag high; an enable rise presets the filter to 16; the filter never moves by more than one step; and the flag changes only at the programmed filter marks. Only the bench's scenarios can show the arithmetic. That covers the gate length, the exact edge count that passes, the pass/fail boundary at 2^win_sel on both sides in both modes, and the number of good or bad gates needed to move the flag, including the extra gates needed once the filter has saturated.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  typedef enum logic [1:0] {
    IFM_IDLE0 = 2'b00,
    IFM_FM    = 2'b01,
    IFM_AM    = 2'b10,
    IFM_IDLE3 = 2'b11
  } ifc_mode_e;

  localparam int FM_BASE_COUNT = 1697;
  localparam int AM_BASE_COUNT = 44;

  function automatic logic mode_is_valid(input logic [1:0] m);
    return (m == IFM_FM) || (m == IFM_AM);
  endfunction

  function automatic int base_count(input logic [1:0] m);
    return (m == IFM_FM) ? FM_BASE_COUNT : AM_BASE_COUNT;
  endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int LAST = STAGES;

  logic [LAST:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[LAST-1:0], async_in};
  end

  assign rise_pulse = shreg[LAST-1] & ~shreg[LAST];
endmodule

// File: rtl/ifc_sample_timer.sv
module ifc_sample_timer #(
  parameter int REF_W = 14,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [REF_W-1:0] ref_div,
  input  logic [DIV_W-1:0] gate_mult,
  output logic             gate_end
);
  logic [REF_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == ref_div);
  assign gate_end = run && !restart && pre_wrap && (div_q == gate_mult);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (run) begin
      if (pre_wrap) begin
        pre_q <= '0;
        div_q <= (div_q == gate_mult) ? '0 : div_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ifc_main_counter.sv
module ifc_main_counter
  import ifc_pkg::*;
#(
  parameter int CNT_W  = 21,
  parameter int TRIM_W = 5,
  parameter int WIN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic              if_edge,
  input  logic              gate_end,
  input  logic [1:0]        mode,
  input  logic [TRIM_W-1:0] center_trim,
  input  logic [WIN_W-1:0]  win_sel,
  output logic              res_valid,
  output logic              res_pass
);
  localparam logic signed [CNT_W-1:0] TWO = CNT_W'(2);

  logic        [CNT_W-1:0] cnt_q;
  logic        [CNT_W-1:0] cnt_next;
  logic        [CNT_W-1:0] preset;
  logic signed [CNT_W-1:0] resid;
  logic signed [CNT_W-1:0] span;
  logic                    in_window;

  assign preset   = CNT_W'(base_count(mode)) + CNT_W'(center_trim) - CNT_W'(1);
  assign cnt_next = cnt_q - CNT_W'(if_edge);

  // Residual (N-1-E): the window |E-N| < 2^w maps to -2^w <= resid <= 2^w-2
  assign resid     = cnt_next;
  assign span      = CNT_W'(1) << win_sel;
  assign in_window = (resid >= -span) && (resid <= span - TWO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      res_valid <= 1'b0;
      res_pass  <= 1'b0;
    end else begin
      res_valid <= gate_end;
      res_pass  <= gate_end && in_window;
      if (restart || gate_end) cnt_q <= preset;
      else if (run)            cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/ifc_stop_filter.sv
module ifc_stop_filter #(
  parameter int FILT_W = 5,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              force_high,
  input  logic              preset,
  input  logic              res_valid,
  input  logic              res_pass,
  input  logic [STEP_W-1:0] stop_step,
  output logic [FILT_W-1:0] level,
  output logic              search_stop
);
  localparam logic [FILT_W-1:0] MID  = FILT_W'(1) << (FILT_W - 1);
  localparam logic [FILT_W-1:0] TOP  = '1;

  logic [FILT_W-1:0] lvl_next;
  logic [FILT_W-1:0] lo_mark;
  logic [FILT_W-1:0] hi_mark;

  assign lo_mark = MID - FILT_W'(stop_step);
  assign hi_mark = MID + FILT_W'(stop_step);

  always_comb begin
    if (res_pass) lvl_next = (level == '0)  ? level : level - 1'b1;
    else          lvl_next = (level == TOP) ? level : level + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level       <= MID;
      search_stop <= 1'b1;
    end else if (force_high) begin
      search_stop <= 1'b1;
    end else if (preset) begin
      level       <= MID;
      search_stop <= 1'b1;
    end else if (res_valid) begin
      level <= lvl_next;
      if (lvl_next == hi_mark)      search_stop <= 1'b1;
      else if (lvl_next == lo_mark) search_stop <= 1'b0;
    end
  end
endmodule

// File: rtl/ifc_station_stop.sv
module ifc_station_stop
  import ifc_pkg::*;
#(
  parameter int REF_W       = 14,
  parameter int DIV_W       = 3,
  parameter int CNT_W       = 21,
  parameter int TRIM_W      = 5,
  parameter int WIN_W       = 3,
  parameter int FILT_W      = 5,
  parameter int STEP_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_in,
  input  logic              ifena,
  input  logic [1:0]        if_mode,
  input  logic [WIN_W-1:0]  win_sel,
  input  logic [TRIM_W-1:0] center_trim,
  input  logic [DIV_W-1:0]  gate_mult,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [STEP_W-1:0] stop_step,
  output logic              meas_strobe,
  output logic              meas_pass,
  output logic              search_stop
);
  logic              ifena_d;
  logic              ena_rise;
  logic              run;
  logic              if_edge;
  logic              gate_end;
  logic [FILT_W-1:0] filt_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ifena_d <= 1'b0;
    else        ifena_d <= ifena;
  end

  assign ena_rise = ifena && !ifena_d;
  assign run      = ifena && mode_is_valid(if_mode);

  ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_in   (if_in),
    .rise_pulse (if_edge)
  );

  ifc_sample_timer #(.REF_W(REF_W), .DIV_W(DIV_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (ena_rise),
    .run       (run),
    .ref_div   (ref_div),
    .gate_mult (gate_mult),
    .gate_end  (gate_end)
  );

  ifc_main_counter #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .WIN_W(WIN_W)) u_main (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (ena_rise),
    .run         (run),
    .if_edge     (if_edge),
    .gate_end    (gate_end),
    .mode        (if_mode),
    .center_trim (center_trim),
    .win_sel     (win_sel),
    .res_valid   (meas_strobe),
    .res_pass    (meas_pass)
  );

  ifc_stop_filter #(.FILT_W(FILT_W), .STEP_W(STEP_W)) u_filt (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_high  (!ifena),
    .preset      (ena_rise),
    .res_valid   (meas_strobe),
    .res_pass    (meas_pass),
    .stop_step   (stop_step),
    .level       (filt_level),
    .search_stop (search_stop)
  );
endmodule

// File: rtl/ifc_station_stop_chk.sv
module ifc_station_stop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ifena,
  input logic [1:0] if_mode,
  input logic [3:0] stop_step,
  input logic       meas_strobe,
  input logic       meas_pass,
  input logic       search_stop,
  input logic [4:0] filt_level
);
  // R1: a verdict only follows a gate that ended in FM or AM mode
  assert_strobe_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    meas_strobe |-> ($past(if_mode) == 2'b01 || $past(if_mode) == 2'b10));

  assert_pass_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_pass |-> meas_strobe);

  assert_low_enable_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ifena |=> search_stop);

  assert_enable_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ifena) |=> (search_stop && filt_level == 5'd16));

  assert_filter_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ifena && $past(ifena) && $past(ifena, 2)) |->
      ({1'b0, filt_level} == {1'b0, $past(filt_level)} ||
       {1'b0, filt_level} == {1'b0, $past(filt_level)} + 6'd1 ||
       {1'b0, filt_level} + 6'd1 == {1'b0, $past(filt_level)}));

  assert_flag_fall_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(search_stop) |-> (filt_level == 5'd16 - {1'b0, stop_step}));

  assert_flag_rise_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(search_stop) |->
      (filt_level == 5'd16 + {1'b0, stop_step} || !$past(ifena) || !$past(ifena, 2)));
endmodule

bind ifc_station_stop ifc_station_stop_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ifena       (ifena),
  .if_mode     (if_mode),
  .stop_step   (stop_step),
  .meas_strobe (meas_strobe),
  .meas_pass   (meas_pass),
  .search_stop (search_stop),
  .filt_level  (filt_level)
);

// File: tb/sim_ifc_station_stop.sv
module sim_ifc_station_stop;
  localparam int CLK_P   = 10;
  localparam int AM_BASE = 44;
  localparam int FM_BASE = 1697;
  localparam int WAIT_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_in = 1'b0;
  logic        ifena = 1'b0;
  logic [1:0]  if_mode = 2'b10;
  logic [2:0]  win_sel = '0;
  logic [4:0]  center_trim = '0;
  logic [2:0]  gate_mult = '0;
  logic [13:0] ref_div = '0;
  logic [3:0]  stop_step = 4'd3;
  logic        meas_strobe, meas_pass, search_stop;

  int n_chk = 0;
  int n_fail = 0;
  bit if_run = 1'b0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if_in <= if_run ? ~if_in : 1'b0;

  ifc_station_stop u0 (
    .clk(clk), .rst_n(rst_n), .if_in(if_in), .ifena(ifena), .if_mode(if_mode),
    .win_sel(win_sel), .center_trim(center_trim), .gate_mult(gate_mult),
    .ref_div(ref_div), .stop_step(stop_step), .meas_strobe(meas_strobe),
    .meas_pass(meas_pass), .search_stop(search_stop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    ifena = 1'b0;
    repeat (3) @(negedge clk);
    ifena = 1'b1;
  endtask

  task automatic wait_strobe(output bit p, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!meas_strobe && cyc < WAIT_LIMIT);
    p = meas_pass;
    if (cyc >= WAIT_LIMIT) check(1'b0, "R5 strobe timeout", cyc, 0);
  endtask

  // after a strobe, let the filter and flag settle, then sample the flag
  task automatic strobe_then_flag(output bit p, output bit flag);
    int c;
    wait_strobe(p, c);
    repeat (2) @(negedge clk);
    flag = search_stop;
  endtask

  task automatic count_strobes(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (meas_strobe) n++;
    end
  endtask

  // Window sweep point: E = N + delta edges per gate (toggle every cycle, gate = 2E)
  task automatic window_point(input logic [1:0] m, input int trim, input int ew, input int delta);
    bit p;
    int c, n_exp, e_cnt, exp_pass, mag;
    n_exp = trim + ((m == 2'b01) ? FM_BASE : AM_BASE);
    e_cnt = n_exp + delta;
    if_mode = m;
    center_trim = 5'(trim);
    win_sel = 3'(ew);
    gate_mult = '0;
    ref_div = 14'(2 * e_cnt - 1);
    restart();
    wait_strobe(p, c);
    mag = (delta < 0) ? -delta : delta;
    exp_pass = (mag < (1 << ew)) ? 1 : 0;
    check(p == exp_pass, (m == 2'b01) ? "R4 FM window" : "R4 AM window", p, exp_pass);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit p, flag;
    int c, n;

    // R9: reset state
    repeat (3) @(negedge clk);
    check(search_stop == 1'b1, "R9 flag in reset", search_stop, 1);
    check(meas_strobe == 1'b0, "R9 strobe in reset", meas_strobe, 0);
    rst_n = 1'b1;
    if_run = 1'b1;
    repeat (2) @(negedge clk);

    // R2, R3: gate length and exact count
    if_mode = 2'b10; center_trim = '0; win_sel = '0;
    ref_div = 14'd10; gate_mult = 3'd7;
    restart();
    wait_strobe(p, c);
    check(c == 89, "R2 first gate latency", c, 89);
    check(p == 1'b1, "R3 exact count passes at win 0", p, 1);
    wait_strobe(p, c);
    check(c == 88, "R2 gate period 11x8", c, 88);
    ref_div = 14'd4; gate_mult = 3'd3;
    restart();
    wait_strobe(p, c);
    wait_strobe(p, c);
    check(c == 20, "R2 gate period 5x4", c, 20);
    check(p == 1'b0, "R3 short gate fails", p, 0);

    // R4 (and R1 base counts): AM sweep around N on both sides
    foreach (center_trim_vals[ti])
      for (int ew = 0; ew < 4; ew++)
        for (int d = -9; d <= 9; d++)
          window_point(2'b10, center_trim_vals[ti], ew, d);
    // R4 FM points
    for (int t = 0; t < 2; t++) begin
      window_point(2'b01, t * 31, 3, -8);
      window_point(2'b01, t * 31, 3, -7);
      window_point(2'b01, t * 31, 3, 7);
      window_point(2'b01, t * 31, 3, 8);
      window_point(2'b01, t * 31, 0, -1);
      window_point(2'b01, t * 31, 0, 0);
      window_point(2'b01, t * 31, 0, 1);
    end

    // R8/R7 filter behaviour: AM, N=44, gate 88 cycles, win 4 edges
    if_mode = 2'b10; center_trim = '0; win_sel = 3'd2;
    ref_div = 14'd87; gate_mult = '0; stop_step = 4'd3;
    if_run = 1'b1;
    restart();
    for (int k = 1; k <= 20; k++) begin
      strobe_then_flag(p, flag);
      check(flag == ((k >= 3) ? 1'b0 : 1'b1), "R8 flag falls after step passes", flag, (k >= 3) ? 0 : 1);
    end

    // R1: unused mode holds everything
    if_mode = 2'b00;
    count_strobes(300, n);
    check(n == 0, "R1 no strobe in mode 00", n, 0);
    check(search_stop == 1'b0, "R1 flag held in mode 00", search_stop, 0);
    if_mode = 2'b11;
    count_strobes(300, n);
    check(n == 0, "R1 no strobe in mode 11", n, 0);
    if_mode = 2'b10;
    strobe_then_flag(p, flag);

    // R7: failures from 0 up to saturation at 31
    if_run = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      strobe_then_flag(p, flag);
      if (k == 18 || k == 19 || k == 40)
        check(flag == ((k >= 19) ? 1'b1 : 1'b0), "R7 R8 flag rises at 16+step", flag, (k >= 19) ? 1 : 0);
    end
    // from 31, 18 passes reach 13 (would be 22 without saturation)
    if_run = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      strobe_then_flag(p, flag);
      if (k >= 16)
        check(flag == ((k >= 18) ? 1'b0 : 1'b1), "R7 saturation at 31", flag, (k >= 18) ? 0 : 1);
    end

    // R6: low enable forces the flag and stops gates
    ifena = 1'b0;
    repeat (2) @(negedge clk);
    check(search_stop == 1'b1, "R6 flag high while disabled", search_stop, 1);
    count_strobes(200, n);
    check(n == 0, "R6 no strobe while disabled", n, 0);
    ifena = 1'b1;
    repeat (2) @(negedge clk);
    check(search_stop == 1'b1, "R6 flag after enable rise", search_stop, 1);
    for (int k = 1; k <= 3; k++) begin
      strobe_then_flag(p, flag);
      check(flag == ((k >= 3) ? 1'b0 : 1'b1), "R6 preset to 16", flag, (k >= 3) ? 0 : 1);
    end

    // R8: step 0 keeps the flag high; step 15 clears at level 1
    stop_step = 4'd0;
    restart();
    for (int k = 1; k <= 20; k++) begin
      strobe_then_flag(p, flag);
      if (k % 5 == 0) check(flag == 1'b1, "R8 step 0 flag stays high", flag, 1);
    end
    stop_step = 4'd15;
    restart();
    for (int k = 1; k <= 15; k++) begin
      strobe_then_flag(p, flag);
      if (k >= 14) check(flag == ((k >= 15) ? 1'b0 : 1'b1), "R8 step 15", flag, (k >= 15) ? 0 : 1);
    end

    // R1: enabling in an unused mode gives no verdicts
    if_mode = 2'b00;
    restart();
    count_strobes(300, n);
    check(n == 0, "R1 no strobe from enable in mode 00", n, 0);
    check(search_stop == 1'b1, "R1 flag stays high in mode 00", search_stop, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  int center_trim_vals [3] = '{0, 13, 31};
endmodule